// File: doc/BRIEF.md
# Frame-Granular Transmit Byte FIFO

This block is a 128-byte circular byte store for outgoing frames. The storage is addressed through four 7-bit pointers. A live write pointer marks the next byte slot to fill. A live read pointer marks the next byte to hand out. A frame-start write pointer holds the committed end of the written data, which is the point a half-written frame can be rolled back to. A frame-start read pointer holds the oldest byte that is still allocated, which is the point a frame can be replayed from.

A producer writes bytes and then either commits the frame, which makes it visible to the reader, or discards it. A consumer reads bytes and then either commits them, which frees the space, or discards them, which rewinds for a retransmission. In auto-commit mode every successful read frees its byte at once. Software can read and overwrite any of the four pointers through a small select/data port. Free space is measured against the frame-start read pointer, not the live read pointer, so bytes that have been read but not released are never overwritten.

Top module: `pkt_fifo`

## Requirements
- R1: After reset all four pointers read as zero, and `rd_fail` and `wr_ovf` are low.
- R2: Software pointer access uses `sw_sel` codes 0 = live write, 1 = live read, 2 = frame-start write, 3 = frame-start read. `sw_rdata` shows the selected pointer in bits 6:0 with bit 7 always zero. A `sw_we` cycle loads `sw_wdata[6:0]` into the selected pointer, and this takes precedence over every other update to that pointer in the same cycle.
- R3: An accepted write stores `wr_data` at the live write offset and advances the live write pointer by one modulo 128, wrapping from 127 to 0.
- R4: A write is rejected when the live write pointer plus one (mod 128) equals the frame-start read pointer. A rejected write leaves the write pointer and the storage unchanged, and `wr_ovf` is high for exactly the following cycle.
- R5: A successful read puts the byte at the live read offset on `rd_data` in the cycle after `rd_en` and advances the live read pointer by one modulo 128.
- R6: A read fails when the live read pointer equals the frame-start write pointer. A failed read returns zero on `rd_data`, raises `rd_fail` for one cycle only, and leaves the read pointer unchanged.
- R7: With `auto_commit` high, each successful read also advances the frame-start read pointer by one.
- R8: `wr_commit` copies the live write pointer into the frame-start write pointer, which makes the written bytes readable.
- R9: `wr_discard` loads the live write pointer from the frame-start write pointer, dropping the uncommitted bytes.
- R10: `rd_commit` copies the live read pointer into the frame-start read pointer. `rd_discard` loads the live read pointer from the frame-start read pointer.
- R11: When a commit or discard command coincides with a data access, the command's pointer load wins over the access's increment, and the data access (including its fail and overflow decision) uses the pointer values from before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_commit | input | 1 | Release each byte on a successful read |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| wr_commit | input | 1 | Commit the written frame |
| wr_discard | input | 1 | Drop the uncommitted written bytes |
| wr_ovf | output | 1 | One-cycle pulse: previous write rejected |
| rd_en | input | 1 | Read strobe |
| rd_commit | input | 1 | Release the bytes read so far |
| rd_discard | input | 1 | Rewind the read pointer to the allocated start |
| rd_data | output | 8 | Byte returned by the previous read |
| rd_fail | output | 1 | One-cycle pulse: previous read found no committed data |
| sw_sel | input | 2 | Pointer select for software access |
| sw_we | input | 1 | Load the selected pointer |
| sw_wdata | input | 8 | Value for the selected pointer (bits 6:0 used) |
| sw_rdata | output | 8 | Selected pointer value, bit 7 zero |

## Verification
The assertions assume that a rewind or software load of a pointer is a deliberate override. For this reason the pointer-hold and pointer-advance properties are conditioned on the absence of `sw_we` to that pointer and of the opposing command in the same cycle. They also assume that `rst` is held for at least one clock edge before any traffic. The stimulus keeps within these limits: it drives each data access alone or with exactly one command, it uses software loads only in cycles with no data access, and it keeps `auto_commit` low during the combined command-and-access cycles. This keeps the frame-start read pointer from moving past the live read pointer.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

    localparam int PTR_W  = 7;
    localparam int DATA_W = 8;

    // software pointer select codes
    typedef enum logic [1:0] {
        SEL_WP  = 2'd0,
        SEL_RP  = 2'd1,
        SEL_SWP = 2'd2,
        SEL_SRP = 2'd3
    } ptr_sel_e;

    // one side's frame command
    typedef struct packed {
        logic commit;
        logic discard;
    } frame_cmd_t;

    // software load strobes, one per pointer
    typedef struct packed {
        logic wp;
        logic rp;
        logic swp;
        logic srp;
    } sw_load_t;

    function automatic sw_load_t decode_load(input logic we, input ptr_sel_e sel);
        sw_load_t l;
        l.wp  = we && (sel == SEL_WP);
        l.rp  = we && (sel == SEL_RP);
        l.swp = we && (sel == SEL_SWP);
        l.srp = we && (sel == SEL_SRP);
        return l;
    endfunction

endpackage

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/pkt_fifo_wr_ctl.sv
module pkt_fifo_wr_ctl
    import pkt_fifo_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  frame_cmd_t       cmd,
    input  logic             ld_wp,
    input  logic             ld_swp,
    input  logic [PTR_W-1:0] ld_val,
    input  logic [PTR_W-1:0] srp_i,
    output logic [PTR_W-1:0] wp_o,
    output logic [PTR_W-1:0] swp_o,
    output logic             mem_we,
    output logic             ovf_o
);
    logic [PTR_W-1:0] wp_q, swp_q, wp_inc;
    logic             ovf_q, full;

    assign wp_inc = wp_q + 1'b1;
    assign full   = (wp_inc == srp_i);
    assign mem_we = wr_en && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            swp_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wr_en && full;

            if (ld_wp)            wp_q <= ld_val;
            else if (cmd.discard) wp_q <= swp_q;
            else if (mem_we)      wp_q <= wp_inc;

            if (ld_swp)           swp_q <= ld_val;
            else if (cmd.commit)  swp_q <= wp_q;
        end
    end

    assign wp_o  = wp_q;
    assign swp_o = swp_q;
    assign ovf_o = ovf_q;

    // R4
    wr_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wp_q + 1'b1) == srp_i && !cmd.discard && !ld_wp)
        |=> ($stable(wp_q) && ovf_q));

    // R9
    wr_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.discard && !ld_wp) |=> (wp_q == $past(swp_q)));

    // R8
    wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.commit && !ld_swp) |=> (swp_q == $past(wp_q)));

endmodule

// File: rtl/pkt_fifo_rd_ctl.sv
module pkt_fifo_rd_ctl
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              auto_commit,
    input  frame_cmd_t        cmd,
    input  logic              ld_rp,
    input  logic              ld_srp,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic [PTR_W-1:0]  swp_i,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  rp_o,
    output logic [PTR_W-1:0]  srp_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              fail_o
);
    logic [PTR_W-1:0]  rp_q, srp_q;
    logic [DATA_W-1:0] data_q;
    logic              fail_q, empty, rd_ok;

    assign empty = (rp_q == swp_i);
    assign rd_ok = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q   <= '0;
            srp_q  <= '0;
            data_q <= '0;
            fail_q <= 1'b0;
        end else begin
            fail_q <= rd_en && empty;
            if (rd_en) data_q <= rd_ok ? mem_rdata : '0;

            if (ld_rp)                     rp_q <= ld_val;
            else if (cmd.discard)          rp_q <= srp_q;
            else if (rd_ok)                rp_q <= rp_q + 1'b1;

            if (ld_srp)                    srp_q <= ld_val;
            else if (cmd.commit)           srp_q <= rp_q;
            else if (rd_ok && auto_commit) srp_q <= srp_q + 1'b1;
        end
    end

    assign rp_o      = rp_q;
    assign srp_o     = srp_q;
    assign rd_data_o = data_q;
    assign fail_o    = fail_q;

    // R6
    rd_fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rp_q == swp_i && !cmd.discard && !ld_rp) |=> $stable(rp_q));

    // R7
    auto_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rp_q != swp_i && auto_commit && !cmd.commit && !ld_srp)
        |=> (srp_q == $past(srp_q) + 1'b1));

    // R10
    rd_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.discard && !ld_rp) |=> (rp_q == $past(srp_q)));

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int DATA_W = pkt_fifo_pkg::DATA_W,
    parameter int PTR_W  = pkt_fifo_pkg::PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_commit,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_commit,
    input  logic              wr_discard,
    output logic              wr_ovf,
    input  logic              rd_en,
    input  logic              rd_commit,
    input  logic              rd_discard,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fail,
    input  logic [1:0]        sw_sel,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata
);
    localparam int PAD_W = DATA_W - PTR_W;

    logic [PTR_W-1:0]  wp, swp, rp, srp, sel_ptr, ld_val;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    sw_load_t          ld;
    frame_cmd_t        wcmd, rcmd;
    ptr_sel_e          sel;

    assign sel    = ptr_sel_e'(sw_sel);
    assign ld     = decode_load(sw_we, sel);
    assign ld_val = sw_wdata[PTR_W-1:0];
    assign wcmd   = '{commit: wr_commit, discard: wr_discard};
    assign rcmd   = '{commit: rd_commit, discard: rd_discard};

    pkt_fifo_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wp),
        .wdata (wr_data),
        .raddr (rp),
        .rdata (mem_rdata)
    );

    pkt_fifo_wr_ctl #(.PTR_W(PTR_W)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .cmd    (wcmd),
        .ld_wp  (ld.wp),
        .ld_swp (ld.swp),
        .ld_val (ld_val),
        .srp_i  (srp),
        .wp_o   (wp),
        .swp_o  (swp),
        .mem_we (mem_we),
        .ovf_o  (wr_ovf)
    );

    pkt_fifo_rd_ctl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .auto_commit (auto_commit),
        .cmd         (rcmd),
        .ld_rp       (ld.rp),
        .ld_srp      (ld.srp),
        .ld_val      (ld_val),
        .swp_i       (swp),
        .mem_rdata   (mem_rdata),
        .rp_o        (rp),
        .srp_o       (srp),
        .rd_data_o   (rd_data),
        .fail_o      (rd_fail)
    );

    always_comb begin
        unique case (sel)
            SEL_WP:  sel_ptr = wp;
            SEL_RP:  sel_ptr = rp;
            SEL_SWP: sel_ptr = swp;
            default: sel_ptr = srp;
        endcase
    end

    assign sw_rdata = {{PAD_W{1'b0}}, sel_ptr};

    // R6
    fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fail |-> (rd_data == '0));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (wp == '0 && rp == '0 && swp == '0 && srp == '0 && !rd_fail && !wr_ovf));

endmodule

// File: tb/sim_pkt_fifo.sv
`timescale 1ns/1ps
module sim_pkt_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_commit = 1'b0;
    logic       wr_en = 1'b0, wr_commit = 1'b0, wr_discard = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0, rd_commit = 1'b0, rd_discard = 1'b0;
    logic [1:0] sw_sel = '0;
    logic       sw_we = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic       wr_ovf, rd_fail;
    logic [7:0] rd_data, sw_rdata;

    always #2.5 clk = ~clk;

    pkt_fifo u0 (
        .clk(clk), .rst(rst), .auto_commit(auto_commit),
        .wr_en(wr_en), .wr_data(wr_data), .wr_commit(wr_commit), .wr_discard(wr_discard),
        .wr_ovf(wr_ovf),
        .rd_en(rd_en), .rd_commit(rd_commit), .rd_discard(rd_discard),
        .rd_data(rd_data), .rd_fail(rd_fail),
        .sw_sel(sw_sel), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    int total = 0;
    int bad   = 0;

    // reference model state, built from the requirements
    logic [7:0] m_mem [128];
    logic [6:0] m_wp = '0, m_rp = '0, m_swp = '0, m_srp = '0;

    typedef struct {
        logic [7:0] data;
        logic       fail;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each read result one edge after its strobe
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= rd_en && !rst;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected read result", 0, 1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_data == e.data, e.tag, rd_data, e.data);
                check(rd_fail == e.fail, {e.tag, " fail flag"}, rd_fail, e.fail);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
    endtask

    // model of one read cycle, pushed to the scoreboard
    task automatic model_read(input string tag);
        exp_t e;
        e.fail = (m_rp == m_swp);
        e.data = e.fail ? 8'h00 : m_mem[m_rp];
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_write(input logic [7:0] b, input string tag);
        logic exp_ovf;
        exp_ovf = ((m_wp + 7'd1) == m_srp);
        if (!exp_ovf) begin
            m_mem[m_wp] = b;
            m_wp = m_wp + 7'd1;
        end
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        check(wr_ovf == exp_ovf, tag, wr_ovf, exp_ovf);
    endtask

    task automatic do_read(input string tag);
        logic ok;
        ok = (m_rp != m_swp);
        model_read(tag);
        if (ok) begin
            m_rp = m_rp + 7'd1;
            if (auto_commit) m_srp = m_srp + 7'd1;
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cmd_wr_commit();
        m_swp = m_wp; wr_commit = 1'b1; @(negedge clk); wr_commit = 1'b0;
    endtask
    task automatic cmd_wr_discard();
        m_wp = m_swp; wr_discard = 1'b1; @(negedge clk); wr_discard = 1'b0;
    endtask
    task automatic cmd_rd_commit();
        m_srp = m_rp; rd_commit = 1'b1; @(negedge clk); rd_commit = 1'b0;
    endtask
    task automatic cmd_rd_discard();
        m_rp = m_srp; rd_discard = 1'b1; @(negedge clk); rd_discard = 1'b0;
    endtask

    task automatic check_ptr(input logic [1:0] sel, input logic [6:0] exp, input string tag);
        sw_sel = sel;
        #0.5;
        check(sw_rdata == {1'b0, exp}, tag, sw_rdata, {1'b0, exp});
    endtask

    task automatic check_all(input string tag);
        check_ptr(2'd0, m_wp,  {tag, " write ptr"});
        check_ptr(2'd1, m_rp,  {tag, " read ptr"});
        check_ptr(2'd2, m_swp, {tag, " frame-start write ptr"});
        check_ptr(2'd3, m_srp, {tag, " frame-start read ptr"});
    endtask

    task automatic sw_load(input logic [1:0] sel, input logic [7:0] v);
        sw_sel = sel; sw_wdata = v; sw_we = 1'b1;
        @(negedge clk);
        sw_we = 1'b0;
        case (sel)
            2'd0: m_wp  = v[6:0];
            2'd1: m_rp  = v[6:0];
            2'd2: m_swp = v[6:0];
            default: m_srp = v[6:0];
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] old_wp, old_rp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_all("R1 reset");
        check(rd_fail == 1'b0 && wr_ovf == 1'b0, "R1 flags low", {rd_fail, wr_ovf}, 0);

        // R6 read on empty
        do_read("R6 empty read");
        idle();
        check(rd_fail == 1'b0, "R6 fail pulse one cycle", rd_fail, 0);
        check_ptr(2'd1, m_rp, "R6 read ptr held");

        // R3 writes, R8 uncommitted data not readable
        do_write(8'hA1, "R3 write a");
        do_write(8'hA2, "R3 write b");
        do_write(8'hA3, "R3 write c");
        check_ptr(2'd0, m_wp, "R3 write ptr advanced");
        do_read("R8 uncommitted read fails");

        // R8 commit then R5 reads
        cmd_wr_commit();
        check_ptr(2'd2, m_swp, "R8 frame-start write copied");
        do_read("R5 read a");
        do_read("R5 read b");
        do_read("R5 read c");
        do_read("R6 read past commit");
        check_ptr(2'd1, m_rp, "R5 read ptr advanced");

        // R10 rewind and replay
        cmd_rd_discard();
        check_ptr(2'd1, m_rp, "R10 rewind read ptr");
        do_read("R10 replay first byte");
        cmd_rd_commit();
        check_ptr(2'd3, m_srp, "R10 commit frame-start read");

        // R9 discard partial frame
        do_write(8'h5A, "R9 partial write a");
        do_write(8'h5B, "R9 partial write b");
        cmd_wr_discard();
        check_ptr(2'd0, m_wp, "R9 write ptr restored");

        // R7 auto-commit
        auto_commit = 1'b1;
        do_read("R7 auto read");
        check_ptr(2'd3, m_srp, "R7 frame-start read advanced");

        // R4 fill to the allocated start, wrapping (R3)
        for (int i = 0; i < 126; i++) do_write(8'(i * 7 + 3), "R3 fill write");
        check_ptr(2'd0, m_wp, "R3 write ptr wrapped");
        do_write(8'hEE, "R4 write rejected");
        check_ptr(2'd0, m_wp, "R4 write ptr held");
        idle();
        check(wr_ovf == 1'b0, "R4 overflow pulse one cycle", wr_ovf, 0);
        cmd_wr_commit();
        for (int i = 0; i < 130; i++) do_read("R5 drain across wrap");
        check_all("R7 after drain");
        auto_commit = 1'b0;

        // R2 software load: bit 7 of value ignored, readback bit 7 zero
        sw_load(2'd1, 8'hD5);
        check_ptr(2'd1, 7'h55, "R2 software load read ptr");
        sw_load(2'd1, {1'b0, m_swp});
        sw_load(2'd3, 8'h80 | {1'b0, m_swp});
        check_all("R2 restored");

        // R11 write with commit: byte stored, commit sees old write ptr
        old_wp = m_wp;
        m_mem[m_wp] = 8'h3C; m_wp = m_wp + 7'd1; m_swp = old_wp;
        wr_en = 1'b1; wr_data = 8'h3C; wr_commit = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_commit = 1'b0;
        check_all("R11 write+commit");
        do_write(8'h3D, "R11 second write");
        cmd_wr_commit();

        // R11 read with rewind: data from old read ptr, rewind wins
        model_read("R11 read+rewind data");
        m_rp = m_srp;
        rd_en = 1'b1; rd_discard = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rd_discard = 1'b0;
        check_ptr(2'd1, m_rp, "R11 rewind beats increment");

        // R11 read with commit: commit takes old read ptr
        old_rp = m_rp;
        model_read("R11 read+commit data");
        m_rp = m_rp + 7'd1; m_srp = old_rp;
        rd_en = 1'b1; rd_commit = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rd_commit = 1'b0;
        check_all("R11 read+commit");
        do_read("R5 final read");
        idle();
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule